// File: doc/BRIEF.md
# Timed Transmit Burst Scheduler

This block sits between a stream of transmit samples and a radio front end that can only transmit or receive at one time. Samples arrive in bursts. Each burst has a start flag, an end flag and, optionally, a 64-bit launch time. The block keeps the samples in a small buffer. It releases them only when a free-running 64-bit sample-time counter reaches the launch time. While a burst is being sent, the block raises a transmit-run signal. This signal enables the downstream transmit path and also drives the antenna changeover, so the front end listens whenever no burst is active.

Software controls the time base in two ways. It can load the counter at once, or it can arm a value that takes effect on the next rising edge of a one-pulse-per-second input. The PPS input passes through a synchronizer first. Some bursts cannot be sent correctly, and the block reports two such cases through sticky flags. A burst whose launch time has already passed is dropped. A burst that runs out of buffered data in mid-flight sends zeros until more samples arrive.

Top module: `tx_burst_sched`

## Requirements
- R1: While reset is held, `cur_time` is 0, `tx_run`, `out_valid`, `late_flag` and `unf_flag` are 0, and `in_ready` is 1.
- R2: With no load pending, `cur_time` increases by exactly one on every clock cycle.
- R3: A cycle with `time_set_now` high makes `cur_time` equal `time_set_val` after the next clock edge. This takes priority over a PPS load.
- R4: A cycle with `time_set_pps` high stores `time_set_val` and arms one load. `pps_in` passes through a two-flop synchronizer and a rising-edge detector. The load happens on the third clock edge that samples `pps_in` high, so `cur_time` equals the stored value after that edge. A PPS edge with nothing armed leaves the counter counting.
- R5: For a burst whose first sample carries a timestamp (`in_has_ts`=1) in the future, `tx_run` stays low and nothing is output until `cur_time` equals the timestamp. `tx_run` is high in that very cycle.
- R6: For a burst whose first sample carries no timestamp, `tx_run` is high in the first cycle after that sample is written.
- R7: While `tx_run` is high, `out_valid` equals `smp_strobe`. Each valid cycle emits the next buffered sample in write order. `tx_run` goes low in the cycle after the sample flagged `in_eob` is emitted.
- R8: If a burst's timestamp is below `cur_time` when the burst reaches the head of the buffer, `late_flag` sets. The flag stays set until `late_clr` is pulsed. Every sample up to and including the end-of-burst sample is dropped, and `tx_run` never rises for that burst.
- R9: If the buffer is empty during a valid cycle of an active burst, `out_valid` is 1 with `out_data` 0, and `unf_flag` sets. The flag stays set until `unf_clr` is pulsed. Emission resumes with real samples once they arrive.
- R10: While no burst is active, a buffered sample without `in_sob` is dropped and produces no output.
- R11: `in_ready` is low exactly when the buffer holds DEPTH samples. A write is accepted only in a cycle with `in_valid` and `in_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_set_val | input | 64 | Value for an immediate or PPS-timed counter load |
| time_set_now | input | 1 | Load the counter at the next edge |
| time_set_pps | input | 1 | Store a value and arm a load on the next PPS edge |
| pps_in | input | 1 | Asynchronous one-pulse-per-second input |
| cur_time | output | 64 | Current sample-time count |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Buffer can accept a sample |
| in_data | input | DW | Sample word |
| in_sob | input | 1 | Sample starts a burst |
| in_eob | input | 1 | Sample ends a burst |
| in_has_ts | input | 1 | Burst start carries a launch time |
| in_ts | input | 64 | Launch time of the burst |
| smp_strobe | input | 1 | Output sample rate enable |
| tx_run | output | 1 | Transmit active; also selects the antenna path |
| out_valid | output | 1 | Output sample present this cycle |
| out_data | output | DW | Output sample, zero on underflow |
| late_flag | output | 1 | Sticky late-burst status |
| late_clr | input | 1 | Clears `late_flag` |
| unf_flag | output | 1 | Sticky underflow status |
| unf_clr | input | 1 | Clears `unf_flag` |

## Verification
The bench targets the exact launch cycle. It polls for the first `tx_run` cycle and compares `cur_time` with the timestamp there, so a scheduler that starts one cycle early or late, or that compares against a stale counter value, is caught. It also aims at bursts that must leave no trace: a late burst or a stray non-start sample that leaks out shows up as an unexpected output in the scoreboard, and a late drop that stops short of the end marker corrupts the order of the next burst. The PPS test counts the synchronizer latency edge by edge and repeats the edge without arming, which exposes a load that comes too early or one that is not cleared after use. The underflow and full-buffer tests check that an emptied buffer gives zero samples rather than stale data, and that `in_ready` falls exactly at DEPTH entries.

// File: rtl/txs_pkg.sv
package txs_pkg;

   localparam int TS_W = 64;

   typedef struct packed {
      logic            sob;
      logic            eob;
      logic            has_ts;
      logic [TS_W-1:0] ts;
   } txs_tag_t;

   localparam int TAG_W = $bits(txs_tag_t);

   typedef enum logic [1:0] {
      TXS_IDLE = 2'd0,
      TXS_RUN  = 2'd1,
      TXS_DROP = 2'd2
   } txs_state_e;

endpackage

// File: rtl/txs_timebase.sv
module txs_timebase import txs_pkg::*; #(
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TS_W-1:0] set_val,
   input  logic            set_now,
   input  logic            set_pps,
   input  logic            pps_in,
   output logic [TS_W-1:0] cur_time
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("txs_timebase: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] pps_sh;
   logic                   pps_prev;
   logic                   pps_rise;
   logic                   armed;
   logic [TS_W-1:0]        pend_val;

   // synchronizer chain, one flop per stage
   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) pps_sh[0] <= 1'b0;
               else        pps_sh[0] <= pps_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) pps_sh[gi] <= 1'b0;
               else        pps_sh[gi] <= pps_sh[gi-1];
            end
         end
      end
   endgenerate

   assign pps_rise = pps_sh[SYNC_STAGES-1] & ~pps_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pps_prev <= 1'b0;
         armed    <= 1'b0;
         pend_val <= '0;
         cur_time <= '0;
      end else begin
         pps_prev <= pps_sh[SYNC_STAGES-1];
         if (set_pps) begin
            armed    <= 1'b1;
            pend_val <= set_val;
         end else if (pps_rise) begin
            armed <= 1'b0;
         end
         if (set_now)
            cur_time <= set_val;
         else if (pps_rise && armed)
            cur_time <= pend_val;
         else
            cur_time <= cur_time + {{(TS_W-1){1'b0}}, 1'b1};
      end
   end

   // R2
   tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_now && !(pps_rise && armed)) |=> cur_time == $past(cur_time) + 64'd1);

   // R3
   load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_now |=> cur_time == $past(set_val));

endmodule

// File: rtl/txs_fifo.sv
module txs_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         full,
   output logic         empty
);

   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("txs_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;

   assign empty   = (wp == rp);
   assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign rd_data = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (wr_en) wp <= wp + 1'b1;
         if (rd_en) rp <= rp + 1'b1;
      end
   end

   // R11
   no_udf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);

   // R11
   no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_en) |=> (wp == $past(wp)));

endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl import txs_pkg::*; #(
   parameter int DW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            head_vld,
   input  txs_tag_t        head_tag,
   input  logic [DW-1:0]   head_data,
   input  logic [TS_W-1:0] cur_time,
   input  logic            smp_strobe,
   input  logic            late_clr,
   input  logic            unf_clr,
   output logic            pop,
   output logic            tx_run,
   output logic            out_valid,
   output logic [DW-1:0]   out_data,
   output logic            late_flag,
   output logic            unf_flag
);

   txs_state_e state, state_nx;
   logic is_start, start_now, go_late, drain, stray, drop;

   always_comb begin
      is_start  = (state == TXS_IDLE) && head_vld && head_tag.sob;
      start_now = is_start && (!head_tag.has_ts || head_tag.ts == cur_time);
      go_late   = is_start && head_tag.has_ts && (head_tag.ts < cur_time);
      tx_run    = (state == TXS_RUN) || start_now;
      out_valid = tx_run && smp_strobe;
      drain     = out_valid && head_vld;
      out_data  = drain ? head_data : '0;
      stray     = (state == TXS_IDLE) && head_vld && !head_tag.sob;
      drop      = (state == TXS_DROP) && head_vld;
      pop       = drain || stray || drop;
   end

   always_comb begin
      state_nx = state;
      unique case (state)
         TXS_IDLE: begin
            if (start_now)    state_nx = (drain && head_tag.eob) ? TXS_IDLE : TXS_RUN;
            else if (go_late) state_nx = TXS_DROP;
         end
         TXS_RUN:  if (drain && head_tag.eob) state_nx = TXS_IDLE;
         TXS_DROP: if (drop && head_tag.eob)  state_nx = TXS_IDLE;
         default:  state_nx = TXS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= TXS_IDLE;
         late_flag <= 1'b0;
         unf_flag  <= 1'b0;
      end else begin
         state <= state_nx;
         if (go_late)       late_flag <= 1'b1;
         else if (late_clr) late_flag <= 1'b0;
         if (out_valid && !head_vld) unf_flag <= 1'b1;
         else if (unf_clr)           unf_flag <= 1'b0;
      end
   end

   // R5
   start_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tx_run) && head_tag.has_ts) |-> head_tag.ts == cur_time);

   // R8
   late_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (late_flag && !late_clr) |=> late_flag);

   // R8
   drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TXS_DROP) |-> !tx_run);

   // R9
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unf_flag && !unf_clr) |=> unf_flag);

endmodule

// File: rtl/tx_burst_sched.sv
module tx_burst_sched import txs_pkg::*; #(
   parameter int DW       = 16,
   parameter int DEPTH    = 16,
   parameter int PPS_SYNC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TS_W-1:0] time_set_val,
   input  logic            time_set_now,
   input  logic            time_set_pps,
   input  logic            pps_in,
   output logic [TS_W-1:0] cur_time,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [DW-1:0]   in_data,
   input  logic            in_sob,
   input  logic            in_eob,
   input  logic            in_has_ts,
   input  logic [TS_W-1:0] in_ts,
   input  logic            smp_strobe,
   output logic            tx_run,
   output logic            out_valid,
   output logic [DW-1:0]   out_data,
   output logic            late_flag,
   input  logic            late_clr,
   output logic            unf_flag,
   input  logic            unf_clr
);

   localparam int WORD_W = TAG_W + DW;

   logic              fifo_full, fifo_empty, wr_en, pop;
   logic [WORD_W-1:0] wr_word, rd_word;
   txs_tag_t          wr_tag, head_tag;
   logic [DW-1:0]     head_data;

   always_comb begin
      wr_tag.sob    = in_sob;
      wr_tag.eob    = in_eob;
      wr_tag.has_ts = in_has_ts;
      wr_tag.ts     = in_ts;
   end

   assign in_ready  = !fifo_full;
   assign wr_en     = in_valid && !fifo_full;
   assign wr_word   = {wr_tag, in_data};
   assign head_tag  = txs_tag_t'(rd_word[DW +: TAG_W]);
   assign head_data = rd_word[DW-1:0];

   txs_timebase #(.SYNC_STAGES(PPS_SYNC)) u_timebase (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_val  (time_set_val),
      .set_now  (time_set_now),
      .set_pps  (time_set_pps),
      .pps_in   (pps_in),
      .cur_time (cur_time)
   );

   txs_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_word),
      .rd_en   (pop),
      .rd_data (rd_word),
      .full    (fifo_full),
      .empty   (fifo_empty)
   );

   txs_ctrl #(.DW(DW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_vld   (!fifo_empty),
      .head_tag   (head_tag),
      .head_data  (head_data),
      .cur_time   (cur_time),
      .smp_strobe (smp_strobe),
      .late_clr   (late_clr),
      .unf_clr    (unf_clr),
      .pop        (pop),
      .tx_run     (tx_run),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .late_flag  (late_flag),
      .unf_flag   (unf_flag)
   );

   // R7
   out_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (tx_run && smp_strobe));

endmodule

// File: tb/tx_burst_sched_bench.sv
module tx_burst_sched_bench;
   import txs_pkg::*;

   localparam int DW    = 16;
   localparam int DEPTH = 16;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [TS_W-1:0] time_set_val;
   logic            time_set_now, time_set_pps, pps_in;
   logic [TS_W-1:0] cur_time;
   logic            in_valid, in_ready, in_sob, in_eob, in_has_ts;
   logic [DW-1:0]   in_data;
   logic [TS_W-1:0] in_ts;
   logic            smp_strobe, tx_run, out_valid;
   logic [DW-1:0]   out_data;
   logic            late_flag, late_clr, unf_flag, unf_clr;

   int n_chk = 0;
   int n_err = 0;
   logic mon_on = 1'b0;
   logic done = 1'b0;
   logic [DW-1:0] exp_q [$];

   always #2 clk = ~clk;

   tx_burst_sched #(.DW(DW), .DEPTH(DEPTH), .PPS_SYNC(2)) u_tx_burst_sched (
      .clk(clk), .rst_n(rst_n),
      .time_set_val(time_set_val), .time_set_now(time_set_now),
      .time_set_pps(time_set_pps), .pps_in(pps_in), .cur_time(cur_time),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_sob(in_sob), .in_eob(in_eob), .in_has_ts(in_has_ts), .in_ts(in_ts),
      .smp_strobe(smp_strobe), .tx_run(tx_run), .out_valid(out_valid),
      .out_data(out_data), .late_flag(late_flag), .late_clr(late_clr),
      .unf_flag(unf_flag), .unf_clr(unf_clr)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [DW-1:0] d, input logic sob, input logic eob,
                       input logic hts, input logic [63:0] ts, input logic expect_out);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_sob = sob; in_eob = eob;
      in_has_ts = hts; in_ts = ts;
      if (expect_out) exp_q.push_back(d);
   endtask

   task automatic stop_in();
      @(negedge clk);
      in_valid = 1'b0; in_sob = 1'b0; in_eob = 1'b0; in_has_ts = 1'b0;
   endtask

   task automatic burst(input int n, input logic [DW-1:0] base, input logic hts,
                        input logic [63:0] ts, input logic expect_out);
      for (int i = 0; i < n; i++)
         send(base + DW'(i), i == 0, i == n - 1, hts, ts, expect_out);
      stop_in();
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      #1;
      if (rst_n && mon_on && out_valid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_err++;
            $display("FAIL R7 unexpected output actual=%0h expected=none", out_data);
         end else begin
            chk("R7 sample order", {48'd0, out_data}, {48'd0, exp_q.pop_front()});
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [63:0] c, ts;
      int bad;
      rst_n = 1'b0; time_set_val = '0; time_set_now = 1'b0; time_set_pps = 1'b0;
      pps_in = 1'b0; in_valid = 1'b0; in_data = '0; in_sob = 1'b0; in_eob = 1'b0;
      in_has_ts = 1'b0; in_ts = '0; smp_strobe = 1'b1; late_clr = 1'b0; unf_clr = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 cur_time", cur_time, 0);
      chk("R1 tx_run", {63'd0, tx_run}, 0);
      chk("R1 out_valid", {63'd0, out_valid}, 0);
      chk("R1 late_flag", {63'd0, late_flag}, 0);
      chk("R1 unf_flag", {63'd0, unf_flag}, 0);
      chk("R1 in_ready", {63'd0, in_ready}, 1);
      @(negedge clk); rst_n = 1'b1; mon_on = 1'b1;

      // R2 free running count
      @(negedge clk); #1; c = cur_time;
      repeat (5) @(negedge clk); #1;
      chk("R2 increment", cur_time, c + 5);

      // R3 immediate load
      @(negedge clk); time_set_val = 64'h0000_0001_0000_0000; time_set_now = 1'b1;
      @(negedge clk); time_set_now = 1'b0; #1;
      chk("R3 load now", cur_time, 64'h0000_0001_0000_0000);

      // R4 PPS-timed load
      @(negedge clk); time_set_val = 64'd5000; time_set_pps = 1'b1;
      @(negedge clk); time_set_pps = 1'b0; #1; c = cur_time;
      repeat (4) @(negedge clk); #1;
      chk("R4 armed waits for pps", cur_time, c + 4);
      @(negedge clk); pps_in = 1'b1;
      repeat (10) @(negedge clk); #1;
      chk("R4 pps load latency", cur_time, 64'd5007);
      @(negedge clk); pps_in = 1'b0;
      repeat (5) @(negedge clk);
      @(negedge clk); pps_in = 1'b1; #1; c = cur_time;
      repeat (10) @(negedge clk); #1;
      chk("R4 unarmed pps ignored", cur_time, c + 10);
      @(negedge clk); pps_in = 1'b0;

      // R6 untimed single-sample burst
      send(16'h0101, 1'b1, 1'b1, 1'b0, 64'd0, 1'b1); #1;
      chk("R6 idle before write", {63'd0, tx_run}, 0);
      stop_in(); #1;
      chk("R6 run after first write", {63'd0, tx_run}, 1);
      chk("R6 first sample out", {48'd0, out_data}, 64'h0101);
      @(negedge clk); #1;
      chk("R7 run ends after eob", {63'd0, tx_run}, 0);

      // R10 stray sample dropped, then a normal untimed burst
      send(16'h0055, 1'b0, 1'b1, 1'b0, 64'd0, 1'b0);
      stop_in();
      repeat (4) @(negedge clk); #1;
      chk("R10 stray gives no run", {63'd0, tx_run}, 0);
      burst(3, 16'h0060, 1'b0, 64'd0, 1'b1);
      repeat (6) @(negedge clk); #1;
      chk("R10 next burst drained", exp_q.size(), 0);

      // R5 timed burst
      @(negedge clk); #1; ts = cur_time + 40;
      burst(4, 16'h0200, 1'b1, ts, 1'b1);
      #1;
      chk("R5 held before time", {63'd0, tx_run}, 0);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk); #1;
         if (tx_run) break;
      end
      chk("R5 start cycle", cur_time, ts);
      repeat (8) @(negedge clk); #1;
      chk("R7 timed burst drained", exp_q.size(), 0);
      chk("R7 run low after burst", {63'd0, tx_run}, 0);

      // R8 late burst discarded
      @(negedge clk); #1; ts = cur_time - 5;
      burst(3, 16'h0300, 1'b1, ts, 1'b0);
      repeat (6) @(negedge clk); #1;
      chk("R8 late flag set", {63'd0, late_flag}, 1);
      chk("R8 no run for late", {63'd0, tx_run}, 0);
      @(negedge clk); late_clr = 1'b1;
      @(negedge clk); late_clr = 1'b0; #1;
      chk("R8 late flag cleared", {63'd0, late_flag}, 0);
      burst(2, 16'h0400, 1'b0, 64'd0, 1'b1);
      repeat (5) @(negedge clk); #1;
      chk("R8 following burst intact", exp_q.size(), 0);

      // R9 underflow
      mon_on = 1'b0;
      send(16'h0011, 1'b1, 1'b0, 1'b0, 64'd0, 1'b0);
      stop_in(); #1;
      chk("R9 first sample", {48'd0, out_data}, 64'h0011);
      @(negedge clk); #1;
      chk("R9 run during gap", {63'd0, tx_run}, 1);
      chk("R9 valid during gap", {63'd0, out_valid}, 1);
      chk("R9 zero during gap", {48'd0, out_data}, 0);
      send(16'h0022, 1'b0, 1'b1, 1'b0, 64'd0, 1'b0); #1;
      chk("R9 flag set", {63'd0, unf_flag}, 1);
      stop_in(); #1;
      chk("R9 resumes with data", {48'd0, out_data}, 64'h0022);
      @(negedge clk); #1;
      chk("R9 run ends at eob", {63'd0, tx_run}, 0);
      unf_clr = 1'b1;
      @(negedge clk); unf_clr = 1'b0; #1;
      chk("R9 flag cleared", {63'd0, unf_flag}, 0);
      mon_on = 1'b1;

      // R7 strobe gating
      @(negedge clk); #1; ts = cur_time + 30;
      burst(4, 16'h0700, 1'b1, ts, 1'b1);
      bad = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         smp_strobe = (i % 2 == 1);
         #1;
         if (out_valid && !smp_strobe) bad++;
         if (tx_run && smp_strobe && !out_valid) bad++;
      end
      smp_strobe = 1'b1;
      chk("R7 valid follows strobe", bad, 0);
      chk("R7 gated burst drained", exp_q.size(), 0);
      chk("R7 gated run low", {63'd0, tx_run}, 0);

      // R11 full buffer
      @(negedge clk); #1; ts = cur_time + 100;
      burst(DEPTH, 16'h0800, 1'b1, ts, 1'b1);
      #1;
      chk("R11 ready low when full", {63'd0, in_ready}, 0);
      repeat (130) @(negedge clk); #1;
      chk("R11 full burst drained", exp_q.size(), 0);
      chk("R11 ready back", {63'd0, in_ready}, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule